// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames that carry one extra bit after the data byte. That bit marks the frame as an address (bit = 1) or as data (bit = 0). The line is oversampled 16 times per bit. The `os_tick` enable marks each oversampling instant. Each bit is decided by a majority vote over the three samples around mid-bit. A finished byte is offered on a valid/ready output. Framing-error, overrun and extra-bit flags sit beside it as plain status pins, together with two level interrupt requests.

Software can arm a wait-for-address filter. It takes effect only when the receiver is set to asynchronous operation and the address mode is selected. While it is active, frames whose extra bit is 0 are dropped: nothing is loaded, no flag rises and no interrupt fires. The first frame with the extra bit at 1 disarms the filter by itself and is handled as a normal frame, so software can read the address. It then decides whether the following data is meant for it.

Back-pressure: the output holds `rx_data` while `rx_valid` is high, and a cycle with `rx_valid` and `rx_ready` both high consumes the byte. The receiver cannot stall the serial line. If a frame completes while a byte is still waiting and `rx_ready` is low in that cycle, the new byte is lost and an overrun is flagged.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a low start bit, 8 data bits with the least significant bit first, the extra (address) bit, and a stop bit, each 16 ticks long. Each bit's value is the majority of its samples at ticks 7, 8 and 9. A start bit whose vote is 1 is discarded and the receiver returns to idle.
- R2: A delivered frame loads `rx_data` and raises `rx_valid`, which holds with `rx_data` stable until a cycle with `rx_ready` high clears it.
- R3: A delivered or overrun frame whose stop-bit vote is 0 sets `st_ferr`.
- R4: If a frame completes while `rx_valid` is 1 and `rx_ready` is 0, `st_ovr` is set and `rx_data` keeps its old byte.
- R5: `st_mpb` is loaded with the extra bit of every frame that is not filtered out.
- R6: `filt_armed` is 0 after reset. The filter acts only while `cfg_async` and `cfg_mp_mode` are both 1. In any other configuration the armed bit stays set, but every frame is delivered.
- R7: While the filter is active, a frame with extra bit 0 changes neither `rx_data`, `rx_valid`, `st_ferr`, `st_ovr`, `st_mpb` nor `filt_armed`, and raises no interrupt, even with a bad stop bit or a waiting byte.
- R8: While the filter is active, a frame with extra bit 1 clears `filt_armed`, sets `st_mpb` and is then handled like a normal frame (R2 to R4).
- R9: A `filt_wr` pulse loads `filt_wdata` into `filt_armed`. Writing 0 disarms the filter, and a write wins over an automatic clear in the same cycle.
- R10: `irq_rx` equals `rx_valid` AND `rx_irq_en`. `irq_err` equals (`st_ferr` OR `st_ovr`) AND `err_irq_en`.
- R11: Pulses on `clr_ferr`, `clr_ovr` and `clr_mpb` clear their flags. A flag set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rx_i | input | 1 | Serial line, idle high |
| cfg_async | input | 1 | 1 = asynchronous operation |
| cfg_mp_mode | input | 1 | 1 = address mode selected |
| filt_wr | input | 1 | Write strobe for the filter bit |
| filt_wdata | input | 1 | Value written to the filter bit |
| rx_irq_en | input | 1 | Receive interrupt enable |
| err_irq_en | input | 1 | Receive-error interrupt enable |
| clr_ferr | input | 1 | Clear framing-error flag |
| clr_ovr | input | 1 | Clear overrun flag |
| clr_mpb | input | 1 | Clear extra-bit flag |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte waiting (data-full) |
| rx_ready | input | 1 | Consumer takes the byte |
| st_ferr | output | 1 | Framing error flag |
| st_ovr | output | 1 | Overrun flag |
| st_mpb | output | 1 | Extra bit of last accepted frame |
| filt_armed | output | 1 | Wait-for-address filter bit |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The bench attacks the filter from every side. It sends data frames with a bad stop bit and data frames arriving onto a still-waiting byte while filtering. A receiver that checked errors before filtering would raise framing or overrun flags there. It sends an address frame onto a waiting byte, which must both disarm the filter and count as an overrun. It sends frames with the filter armed but the mode bits off, where a design that ignored the mode gating would drop them. Single-cycle glitches inside a bit and a runt start pulse probe the vote, which a single-sample design would corrupt or mistake for a frame.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              mpb;
    logic              stop_ok;
  } mpr_frame_t;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mpr_sampler.sv
module mpr_sampler
  import mpr_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  output logic       done,
  output mpr_frame_t frame
);
  localparam int unsigned CW    = $clog2(OVS);
  localparam int unsigned NBITS = DATA_W + 3;
  localparam int unsigned IW    = $clog2(NBITS + 1);
  localparam logic [CW-1:0] MID_LO = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] MID_HI = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST   = CW'(OVS - 1);
  localparam logic [IW-1:0] IDX_MP = IW'(DATA_W + 1);

  logic              busy;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [1:0]        ones;
  logic [DATA_W-1:0] shreg;
  logic              mpb_q, stop_q;
  logic              vote;

  assign vote = (ones >= 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      ones  <= '0;
      shreg <= '0;
      mpb_q <= 1'b0;
      stop_q <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (!busy) begin
          if (!rx_s) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
            idx  <= '0;
            ones <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt >= MID_LO && cnt <= MID_HI && rx_s) ones <= ones + 1'b1;
          if (cnt == LAST) begin
            ones <= '0;
            idx  <= idx + 1'b1;
            if (idx == '0) begin
              if (vote) busy <= 1'b0;
            end else if (idx <= IW'(DATA_W)) begin
              shreg <= {vote, shreg[DATA_W-1:1]};
            end else if (idx == IDX_MP) begin
              mpb_q <= vote;
            end else begin
              stop_q <= vote;
              busy   <= 1'b0;
              done   <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign frame = '{data: shreg, mpb: mpb_q, stop_ok: stop_q};
endmodule

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  mpr_frame_t        frame,
  input  logic              cfg_async,
  input  logic              cfg_mp_mode,
  input  logic              filt_wr,
  input  logic              filt_wdata,
  input  logic              clr_ferr,
  input  logic              clr_ovr,
  input  logic              clr_mpb,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              st_ferr,
  output logic              st_ovr,
  output logic              st_mpb,
  output logic              filt_armed
);
  logic active, drop, accept;

  assign active = cfg_async & cfg_mp_mode & filt_armed;
  assign drop   = done & active & ~frame.mpb;
  assign accept = done & ~drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      st_ferr    <= 1'b0;
      st_ovr     <= 1'b0;
      st_mpb     <= 1'b0;
      filt_armed <= 1'b0;
    end else begin
      if (clr_ferr) st_ferr <= 1'b0;
      if (clr_ovr)  st_ovr  <= 1'b0;
      if (clr_mpb)  st_mpb  <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (accept) begin
        st_mpb <= frame.mpb;
        if (active) filt_armed <= 1'b0;
        if (!frame.stop_ok) st_ferr <= 1'b1;
        if (rx_valid && !rx_ready) begin
          st_ovr <= 1'b1;
        end else begin
          rx_data  <= frame.data;
          rx_valid <= 1'b1;
        end
      end
      if (filt_wr) filt_armed <= filt_wdata;
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpr_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_i,
  input  logic              cfg_async,
  input  logic              cfg_mp_mode,
  input  logic              filt_wr,
  input  logic              filt_wdata,
  input  logic              rx_irq_en,
  input  logic              err_irq_en,
  input  logic              clr_ferr,
  input  logic              clr_ovr,
  input  logic              clr_mpb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              st_ferr,
  output logic              st_ovr,
  output logic              st_mpb,
  output logic              filt_armed,
  output logic              irq_rx,
  output logic              irq_err
);
  logic       rx_s;
  logic       fdone;
  mpr_frame_t frame;

  mpr_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
  );

  mpr_sampler #(.OVS(OVS)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s),
    .done(fdone), .frame(frame)
  );

  mpr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .done(fdone), .frame(frame),
    .cfg_async(cfg_async), .cfg_mp_mode(cfg_mp_mode),
    .filt_wr(filt_wr), .filt_wdata(filt_wdata),
    .clr_ferr(clr_ferr), .clr_ovr(clr_ovr), .clr_mpb(clr_mpb),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .st_ferr(st_ferr), .st_ovr(st_ovr), .st_mpb(st_mpb),
    .filt_armed(filt_armed)
  );

  assign irq_rx  = rx_valid & rx_irq_en;
  assign irq_err = (st_ferr | st_ovr) & err_irq_en;
endmodule

// File: rtl/mpr_chk.sv
module mpr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_async,
  input logic       cfg_mp_mode,
  input logic       filt_wr,
  input logic       rx_ready,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       st_ferr,
  input logic       st_ovr,
  input logic       st_mpb,
  input logic       filt_armed,
  input logic       frame_done
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !frame_done |=> !rx_valid);

  p_keep_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> rx_valid && $stable(rx_data));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(filt_armed && cfg_async && cfg_mp_mode && !filt_wr) && filt_armed
    |-> !$rose(rx_valid) && !$rose(st_ferr) && !$rose(st_ovr));

  p_addr_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_armed) && !$past(filt_wr) |-> st_mpb);
endmodule

bind mp_uart_rx mpr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_mp_mode(cfg_mp_mode),
  .filt_wr(filt_wr), .rx_ready(rx_ready), .rx_valid(rx_valid),
  .rx_data(rx_data), .st_ferr(st_ferr), .st_ovr(st_ovr), .st_mpb(st_mpb),
  .filt_armed(filt_armed), .frame_done(fdone)
);

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b1;
  logic rx_i = 1'b1;
  logic cfg_async = 1'b1, cfg_mp_mode = 1'b0;
  logic filt_wr = 1'b0, filt_wdata = 1'b0;
  logic rx_irq_en = 1'b1, err_irq_en = 1'b1;
  logic clr_ferr = 1'b0, clr_ovr = 1'b0, clr_mpb = 1'b0;
  logic rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, st_ferr, st_ovr, st_mpb, filt_armed, irq_rx, irq_err;

  int n_chk = 0, n_bad = 0;
  logic [7:0] last_data = 8'h00;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  mp_uart_rx dut (.*);

  // {async, mp_mode, arm, data[7:0], mpb, stop, exp_full, exp_ferr, exp_armed}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'hA5,1'b0,1'b1,1'b1,1'b0,1'b0}, // R1 R2 plain
    {1'b1,1'b0,1'b0,8'h81,1'b0,1'b0,1'b1,1'b1,1'b0}, // R3 bad stop
    {1'b1,1'b1,1'b0,8'h3C,1'b1,1'b1,1'b1,1'b0,1'b0}, // R5 address, unarmed
    {1'b1,1'b1,1'b1,8'h77,1'b0,1'b1,1'b0,1'b0,1'b1}, // R7 dropped
    {1'b1,1'b1,1'b1,8'hF0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R7 bad stop hidden
    {1'b1,1'b1,1'b1,8'h42,1'b1,1'b1,1'b1,1'b0,1'b0}, // R8 address ends wait
    {1'b1,1'b1,1'b1,8'h19,1'b1,1'b0,1'b1,1'b1,1'b0}, // R8 address, bad stop
    {1'b0,1'b1,1'b1,8'h66,1'b0,1'b1,1'b1,1'b0,1'b1}, // R6 not async
    {1'b1,1'b0,1'b1,8'hC3,1'b0,1'b1,1'b1,1'b0,1'b1}, // R6 mode off
    {1'b1,1'b1,1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,1'b1}  // R7 zero byte
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_at >= 0 flips the line for one cycle, 8 cycles into bit glitch_at
  task automatic send(input logic [7:0] d, input logic mpb, input logic stp, input int glitch_at);
    logic [10:0] bits;
    bits = {stp, mpb, d, 1'b0};
    for (int b = 0; b < 11; b++) begin
      for (int t = 0; t < 16; t++) begin
        rx_i = (b == glitch_at && t == 8) ? ~bits[b] : bits[b];
        @(negedge clk);
      end
    end
    rx_i = 1'b1;
    cyc(10);
  endtask

  task automatic clean();
    rx_ready = rx_valid;
    clr_ferr = 1'b1; clr_ovr = 1'b1; clr_mpb = 1'b1;
    filt_wr = 1'b1; filt_wdata = 1'b0;
    @(negedge clk);
    rx_ready = 1'b0; clr_ferr = 1'b0; clr_ovr = 1'b0; clr_mpb = 1'b0;
    filt_wr = 1'b0;
  endtask

  task automatic arm(input logic v);
    filt_wr = 1'b1; filt_wdata = v;
    @(negedge clk);
    filt_wr = 1'b0;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    // R6 reset state
    chk("R6 reset armed", filt_armed, 0);
    chk("R2 reset valid", rx_valid, 0);
    chk("R11 reset flags", {st_ferr, st_ovr, st_mpb}, 0);
    chk("R10 reset irq", {irq_rx, irq_err}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      clean();
      cfg_async = v[15]; cfg_mp_mode = v[14];
      if (v[13]) arm(1'b1);
      send(v[12:5], v[4], v[3], -1);
      if (v[2]) last_data = v[12:5];
      chk($sformatf("R2 R7 vec%0d valid", i), rx_valid, v[2]);
      chk($sformatf("R2 R7 vec%0d data", i), rx_data, last_data);
      chk($sformatf("R3 vec%0d ferr", i), st_ferr, v[1]);
      chk($sformatf("R5 vec%0d mpb", i), st_mpb, v[2] ? v[4] : 1'b0);
      chk($sformatf("R6 R8 vec%0d armed", i), filt_armed, v[0]);
      chk($sformatf("R10 vec%0d irq", i), {irq_rx, irq_err}, {v[2], v[1]});
    end

    // R4 overrun keeps old byte
    clean(); cfg_async = 1'b1; cfg_mp_mode = 1'b1;
    send(8'h11, 1'b0, 1'b1, -1);
    send(8'h22, 1'b0, 1'b1, -1);
    chk("R4 ovr set", st_ovr, 1);
    chk("R4 data kept", rx_data, 8'h11);
    chk("R10 irq_err on ovr", irq_err, 1);

    // R7 filtered frame onto waiting byte: no overrun, no framing error
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    chk("R11 clr ovr", st_ovr, 0);
    arm(1'b1);
    send(8'h55, 1'b0, 1'b0, -1);
    chk("R7 no ovr while filtering", {st_ovr, st_ferr}, 0);
    chk("R7 data untouched", rx_data, 8'h11);

    // R8 address onto waiting byte: disarms and overruns
    send(8'h99, 1'b1, 1'b1, -1);
    chk("R8 disarmed", filt_armed, 0);
    chk("R8 mpb set", st_mpb, 1);
    chk("R4 R8 ovr on address", st_ovr, 1);
    chk("R4 R8 data kept", rx_data, 8'h11);

    // R9 software disarm
    clean(); arm(1'b1);
    chk("R9 armed", filt_armed, 1);
    arm(1'b0);
    chk("R9 disarmed by write", filt_armed, 0);
    send(8'h5A, 1'b0, 1'b1, -1);
    chk("R9 delivered after disarm", {rx_valid, rx_data}, {1'b1, 8'h5A});

    // R10 enables gate the requests
    clean(); rx_irq_en = 1'b0; err_irq_en = 1'b0;
    send(8'hE7, 1'b0, 1'b0, -1);
    chk("R10 masked irq", {irq_rx, irq_err}, 0);
    chk("R10 flags still set", {rx_valid, st_ferr}, 2'b11);
    rx_irq_en = 1'b1; err_irq_en = 1'b1;
    @(negedge clk);
    chk("R10 unmasked irq", {irq_rx, irq_err}, 2'b11);

    // R11 individual clears
    clr_ferr = 1'b1; @(negedge clk); clr_ferr = 1'b0;
    chk("R11 clr ferr", st_ferr, 0);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    chk("R2 pop clears valid", rx_valid, 0);

    // R1 glitch rejected by vote
    clean();
    send(8'h00, 1'b0, 1'b1, 4);
    chk("R1 glitch in data bit", rx_data, 8'h00);
    clean();
    send(8'hFF, 1'b1, 1'b1, 9);
    chk("R1 glitch in extra bit", {rx_data, st_mpb}, {8'hFF, 1'b1});

    // R1 runt start pulse ignored
    clean();
    rx_i = 1'b0; cyc(4); rx_i = 1'b1; cyc(200);
    chk("R1 runt start", rx_valid, 0);
    send(8'h6D, 1'b0, 1'b1, -1);
    chk("R1 after runt", {rx_valid, rx_data}, {1'b1, 8'h6D});

    summary();
  end
endmodule